// File: doc/BRIEF.md
# Taint-Tracking Predicated Register File

This block holds the architectural register state of a small processor core in which every bit is paired with a trust bit. Zero means trusted and one means untrusted. There are eight 32-bit general-purpose registers and two single-bit predicate registers. Each data bit and each predicate value has its own trust bit.

A write never branches. The write instruction always issues and names one of the predicate registers. The current value of that predicate decides whether the destination takes the new word. The trust of that predicate decides how the destination's shadow bits are updated. If the predicate is untrusted, the destination's shadow bits become all ones whether or not the data was replaced. The destination index is trusted, so only the addressed register can be marked untrusted.

Predicate registers are loaded from a separate compare-result port. The trust bit stored with the predicate is the OR of every taint bit of the two compare operands. Two independent read ports return a register word together with its shadow vector. The current value and trust of both predicates are always visible. Reads are taken straight from the registers, so a write shows up on the read ports one cycle later.

Top module: `shadow_regfile`

## Requirements
- R1: After reset, every general-purpose register reads data 0 with taint 0, and both predicates read value 0 with trust bit 0.
- R2: A write with a trusted predicate whose value is 1 loads the destination with the write data and the write taint vector.
- R3: A write with a trusted predicate whose value is 0 leaves the destination's data and taint unchanged.
- R4: A write with an untrusted predicate whose value is 1 loads the write data and sets every taint bit of the destination to 1, ignoring the write taint vector.
- R5: A write with an untrusted predicate whose value is 0 keeps the destination's data and sets every taint bit of the destination to 1.
- R6: A write changes no general-purpose register other than the one named by the write index.
- R7: A compare update stores the result bit in the selected predicate. Its trust bit is the OR of all bits of both operand taint vectors, so it is 0 only if both vectors are all zero.
- R8: There is no bypass. In the cycle a write is presented, a read of the same register returns the old contents, and the new contents appear after the clock edge.
- R9: While the write enable is low, no general-purpose register changes, whatever values the other write inputs carry.
- R10: The two read ports select registers independently, and each returns the data and taint of its own selected register in the same cycle.
- R11: A write and a compare update to the same predicate in one cycle: the write uses the predicate value and trust held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Issue a predicated register write |
| wr_idx_i | input | 3 | Destination register index |
| wr_data_i | input | 32 | Data to write |
| wr_taint_i | input | 32 | Per-bit taint of the write data |
| wr_psel_i | input | 1 | Index of the controlling predicate register |
| cmp_en_i | input | 1 | Load a compare result into a predicate register |
| cmp_idx_i | input | 1 | Predicate register to load |
| cmp_result_i | input | 1 | Compare outcome |
| cmp_opa_taint_i | input | 32 | Taint vector of the first compare operand |
| cmp_opb_taint_i | input | 32 | Taint vector of the second compare operand |
| rd0_idx_i | input | 3 | Read port 0 register index |
| rd0_data_o | output | 32 | Read port 0 data |
| rd0_taint_o | output | 32 | Read port 0 taint vector |
| rd1_idx_i | input | 3 | Read port 1 register index |
| rd1_data_o | output | 32 | Read port 1 data |
| rd1_taint_o | output | 32 | Read port 1 taint vector |
| pred_val_o | output | 2 | Current predicate values |
| pred_taint_o | output | 2 | Current predicate trust bits |

## Verification
The hardest case to reach is a suppressed write under an untrusted predicate. Before it can happen, a compare must load a 0 result from operands with at least one taint bit set, and the destination must already hold a known, distinctive value. The bench first loads a trusted predicate with 1, writes a marker word, and reloads the second predicate through a tainted compare. It then issues the write, so the kept data and the forced shadow bits can be told apart. The same-cycle case, where a compare and a write hit the same predicate, is reached by driving both ports in a single cycle.

// File: rtl/srf_pkg.sv
package srf_pkg;

   typedef enum logic [1:0] {
      WK_KEEP       = 2'd0,
      WK_LOAD       = 2'd1,
      WK_SHADE      = 2'd2,
      WK_LOAD_SHADE = 2'd3
   } srf_wr_kind_e;

   function automatic srf_wr_kind_e srf_classify(input logic en,
                                                 input logic pval,
                                                 input logic ptnt);
      srf_wr_kind_e k;
      if (!en)
         k = WK_KEEP;
      else if (ptnt)
         k = pval ? WK_LOAD_SHADE : WK_SHADE;
      else
         k = pval ? WK_LOAD : WK_KEEP;
      return k;
   endfunction

endpackage

// File: rtl/srf_wr_gate.sv
module srf_wr_gate
   import srf_pkg::*;
#(
   parameter int NUM_PRED = 2,
   localparam int PSEL_W = $clog2(NUM_PRED)
) (
   input  logic                wr_en_i,
   input  logic [PSEL_W-1:0]   psel_i,
   input  logic [NUM_PRED-1:0] pred_val_i,
   input  logic [NUM_PRED-1:0] pred_taint_i,
   output srf_wr_kind_e        kind_o
);
   logic sel_val;
   logic sel_tnt;

   always_comb begin
      sel_val = pred_val_i[psel_i];
      sel_tnt = pred_taint_i[psel_i];
      kind_o  = srf_classify(wr_en_i, sel_val, sel_tnt);
   end
endmodule

// File: rtl/srf_gpr_bank.sv
module srf_gpr_bank
   import srf_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_GPR = 8,
   localparam int IDX_W  = $clog2(NUM_GPR)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  srf_wr_kind_e                     kind_i,
   input  logic [IDX_W-1:0]                 idx_i,
   input  logic [DATA_W-1:0]                data_i,
   input  logic [DATA_W-1:0]                taint_i,
   output logic [NUM_GPR-1:0][DATA_W-1:0]   data_q,
   output logic [NUM_GPR-1:0][DATA_W-1:0]   taint_q
);
   for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
      logic hit;
      assign hit = (idx_i == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[g]  <= '0;
            taint_q[g] <= '0;
         end else if (hit) begin
            unique case (kind_i)
               WK_LOAD: begin
                  data_q[g]  <= data_i;
                  taint_q[g] <= taint_i;
               end
               WK_SHADE: begin
                  taint_q[g] <= '1;
               end
               WK_LOAD_SHADE: begin
                  data_q[g]  <= data_i;
                  taint_q[g] <= '1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/srf_pred_bank.sv
module srf_pred_bank #(
   parameter int DATA_W   = 32,
   parameter int NUM_PRED = 2,
   localparam int PSEL_W  = $clog2(NUM_PRED)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmp_en_i,
   input  logic [PSEL_W-1:0]   cmp_idx_i,
   input  logic                cmp_result_i,
   input  logic [DATA_W-1:0]   opa_taint_i,
   input  logic [DATA_W-1:0]   opb_taint_i,
   output logic [NUM_PRED-1:0] val_q,
   output logic [NUM_PRED-1:0] taint_q
);
   logic any_taint;
   assign any_taint = (|opa_taint_i) | (|opb_taint_i);

   for (genvar p = 0; p < NUM_PRED; p++) begin : g_pred
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q[p]   <= 1'b0;
            taint_q[p] <= 1'b0;
         end else if (cmp_en_i && (cmp_idx_i == PSEL_W'(p))) begin
            val_q[p]   <= cmp_result_i;
            taint_q[p] <= any_taint;
         end
      end
   end
endmodule

// File: rtl/srf_read_port.sv
module srf_read_port #(
   parameter int DATA_W  = 32,
   parameter int NUM_GPR = 8,
   localparam int IDX_W  = $clog2(NUM_GPR)
) (
   input  logic [NUM_GPR-1:0][DATA_W-1:0] data_i,
   input  logic [NUM_GPR-1:0][DATA_W-1:0] taint_i,
   input  logic [IDX_W-1:0]               idx_i,
   output logic [DATA_W-1:0]              data_o,
   output logic [DATA_W-1:0]              taint_o
);
   assign data_o  = data_i[idx_i];
   assign taint_o = taint_i[idx_i];
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
   import srf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_GPR  = 8,
   parameter int NUM_PRED = 2,
   localparam int IDX_W   = $clog2(NUM_GPR),
   localparam int PSEL_W  = $clog2(NUM_PRED)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   input  logic [DATA_W-1:0]   wr_taint_i,
   input  logic [PSEL_W-1:0]   wr_psel_i,
   input  logic                cmp_en_i,
   input  logic [PSEL_W-1:0]   cmp_idx_i,
   input  logic                cmp_result_i,
   input  logic [DATA_W-1:0]   cmp_opa_taint_i,
   input  logic [DATA_W-1:0]   cmp_opb_taint_i,
   input  logic [IDX_W-1:0]    rd0_idx_i,
   output logic [DATA_W-1:0]   rd0_data_o,
   output logic [DATA_W-1:0]   rd0_taint_o,
   input  logic [IDX_W-1:0]    rd1_idx_i,
   output logic [DATA_W-1:0]   rd1_data_o,
   output logic [DATA_W-1:0]   rd1_taint_o,
   output logic [NUM_PRED-1:0] pred_val_o,
   output logic [NUM_PRED-1:0] pred_taint_o
);
   if (DATA_W < 1) begin : g_bad_width
      $error("shadow_regfile: DATA_W must be at least 1");
   end
   if (NUM_GPR < 2 || (NUM_GPR & (NUM_GPR - 1)) != 0) begin : g_bad_gpr
      $error("shadow_regfile: NUM_GPR must be a power of two, at least 2");
   end
   if (NUM_PRED < 2 || (NUM_PRED & (NUM_PRED - 1)) != 0) begin : g_bad_pred
      $error("shadow_regfile: NUM_PRED must be a power of two, at least 2");
   end

   srf_wr_kind_e                   wr_kind;
   logic [NUM_GPR-1:0][DATA_W-1:0] gpr_data;
   logic [NUM_GPR-1:0][DATA_W-1:0] gpr_taint;

   srf_pred_bank #(.DATA_W(DATA_W), .NUM_PRED(NUM_PRED)) u_pred (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmp_en_i     (cmp_en_i),
      .cmp_idx_i    (cmp_idx_i),
      .cmp_result_i (cmp_result_i),
      .opa_taint_i  (cmp_opa_taint_i),
      .opb_taint_i  (cmp_opb_taint_i),
      .val_q        (pred_val_o),
      .taint_q      (pred_taint_o)
   );

   srf_wr_gate #(.NUM_PRED(NUM_PRED)) u_gate (
      .wr_en_i      (wr_en_i),
      .psel_i       (wr_psel_i),
      .pred_val_i   (pred_val_o),
      .pred_taint_i (pred_taint_o),
      .kind_o       (wr_kind)
   );

   srf_gpr_bank #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind_i  (wr_kind),
      .idx_i   (wr_idx_i),
      .data_i  (wr_data_i),
      .taint_i (wr_taint_i),
      .data_q  (gpr_data),
      .taint_q (gpr_taint)
   );

   srf_read_port #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_rd0 (
      .data_i  (gpr_data),
      .taint_i (gpr_taint),
      .idx_i   (rd0_idx_i),
      .data_o  (rd0_data_o),
      .taint_o (rd0_taint_o)
   );

   srf_read_port #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_rd1 (
      .data_i  (gpr_data),
      .taint_i (gpr_taint),
      .idx_i   (rd1_idx_i),
      .data_o  (rd1_data_o),
      .taint_o (rd1_taint_o)
   );
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
   parameter int DATA_W   = 32,
   parameter int NUM_GPR  = 8,
   parameter int NUM_PRED = 2,
   localparam int IDX_W   = $clog2(NUM_GPR),
   localparam int PSEL_W  = $clog2(NUM_PRED)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             wr_en_i,
   input logic [IDX_W-1:0]                 wr_idx_i,
   input logic [DATA_W-1:0]                wr_data_i,
   input logic [DATA_W-1:0]                wr_taint_i,
   input logic [PSEL_W-1:0]                wr_psel_i,
   input logic                             cmp_en_i,
   input logic [PSEL_W-1:0]                cmp_idx_i,
   input logic                             cmp_result_i,
   input logic [DATA_W-1:0]                cmp_opa_taint_i,
   input logic [DATA_W-1:0]                cmp_opb_taint_i,
   input logic [NUM_PRED-1:0]              pred_val_o,
   input logic [NUM_PRED-1:0]              pred_taint_o,
   input logic [NUM_GPR-1:0][DATA_W-1:0]   gpr_data,
   input logic [NUM_GPR-1:0][DATA_W-1:0]   gpr_taint
);
   logic sel_v;
   logic sel_t;
   assign sel_v = pred_val_o[wr_psel_i];
   assign sel_t = pred_taint_o[wr_psel_i];

   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (gpr_data == '0 && gpr_taint == '0 &&
                        pred_val_o == '0 && pred_taint_o == '0)); // R1

   AST_TRUSTED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !sel_t && sel_v) |=>
         (gpr_data[$past(wr_idx_i)] == $past(wr_data_i) &&
          gpr_taint[$past(wr_idx_i)] == $past(wr_taint_i))); // R2

   AST_TRUSTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !sel_t && !sel_v) |=>
         ($stable(gpr_data) && $stable(gpr_taint))); // R3

   AST_UNTRUSTED_SHADE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && sel_t) |=> (gpr_taint[$past(wr_idx_i)] == '1)); // R4

   AST_UNTRUSTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && sel_t && !sel_v) |=> $stable(gpr_data)); // R5

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(gpr_data) && $stable(gpr_taint))); // R9

   AST_CMP_TRUST: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en_i |=> (pred_taint_o[$past(cmp_idx_i)] ==
                    $past((|cmp_opa_taint_i) | (|cmp_opb_taint_i)) &&
                    pred_val_o[$past(cmp_idx_i)] == $past(cmp_result_i))); // R7
endmodule

bind shadow_regfile srf_checker #(
   .DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .NUM_PRED(NUM_PRED)
) u_srf_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en_i         (wr_en_i),
   .wr_idx_i        (wr_idx_i),
   .wr_data_i       (wr_data_i),
   .wr_taint_i      (wr_taint_i),
   .wr_psel_i       (wr_psel_i),
   .cmp_en_i        (cmp_en_i),
   .cmp_idx_i       (cmp_idx_i),
   .cmp_result_i    (cmp_result_i),
   .cmp_opa_taint_i (cmp_opa_taint_i),
   .cmp_opb_taint_i (cmp_opb_taint_i),
   .pred_val_o      (pred_val_o),
   .pred_taint_o    (pred_taint_o),
   .gpr_data        (gpr_data),
   .gpr_taint       (gpr_taint)
);

// File: tb/shadow_regfile_bench.sv
module shadow_regfile_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] wr_taint = '0;
   logic        wr_psel = 1'b0;
   logic        cmp_en = 1'b0;
   logic        cmp_idx = 1'b0;
   logic        cmp_result = 1'b0;
   logic [31:0] cmp_a = '0;
   logic [31:0] cmp_b = '0;
   logic [2:0]  rd0_idx = '0;
   logic [2:0]  rd1_idx = '0;
   logic [31:0] rd0_data, rd0_taint, rd1_data, rd1_taint;
   logic [1:0]  pred_val, pred_taint;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shadow_regfile u_shadow_regfile (
      .clk (clk), .rst_n (rst_n),
      .wr_en_i (wr_en), .wr_idx_i (wr_idx), .wr_data_i (wr_data),
      .wr_taint_i (wr_taint), .wr_psel_i (wr_psel),
      .cmp_en_i (cmp_en), .cmp_idx_i (cmp_idx), .cmp_result_i (cmp_result),
      .cmp_opa_taint_i (cmp_a), .cmp_opb_taint_i (cmp_b),
      .rd0_idx_i (rd0_idx), .rd0_data_o (rd0_data), .rd0_taint_o (rd0_taint),
      .rd1_idx_i (rd1_idx), .rd1_data_o (rd1_data), .rd1_taint_o (rd1_taint),
      .pred_val_o (pred_val), .pred_taint_o (pred_taint)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic read_reg(input int idx, input string tag,
                           input logic [31:0] ed, input logic [31:0] et);
      rd0_idx = 3'(idx);
      #1;
      chk({tag, " data"}, rd0_data, ed);
      chk({tag, " taint"}, rd0_taint, et);
   endtask

   task automatic pset(input bit idx, input bit val,
                       input logic [31:0] ta, input logic [31:0] tb);
      @(negedge clk);
      cmp_en = 1'b1; cmp_idx = idx; cmp_result = val; cmp_a = ta; cmp_b = tb;
      @(negedge clk);
      cmp_en = 1'b0; cmp_a = '0; cmp_b = '0;
   endtask

   task automatic wr(input int idx, input logic [31:0] d, input logic [31:0] t, input bit ps);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d; wr_taint = t; wr_psel = ps;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) read_reg(i, "R1 reset", 32'h0, 32'h0);
      chk("R1 pred val", 32'(pred_val), 32'h0);
      chk("R1 pred taint", 32'(pred_taint), 32'h0);
   endtask

   task automatic t_trusted_load;
      pset(1'b0, 1'b1, '0, '0);
      wr(3, 32'hA5A5_3C3C, 32'h0000_F0F0, 1'b0);
      rd0_idx = 3'd3; rd1_idx = 3'd5;
      #1;
      chk("R2 data", rd0_data, 32'hA5A5_3C3C);
      chk("R2 taint", rd0_taint, 32'h0000_F0F0);
      chk("R10 port1 data", rd1_data, 32'h0);
      chk("R10 port1 taint", rd1_taint, 32'h0);
      rd0_idx = 3'd5; rd1_idx = 3'd3;
      #1;
      chk("R10 swap port1 data", rd1_data, 32'hA5A5_3C3C);
      chk("R10 swap port0 data", rd0_data, 32'h0);
   endtask

   task automatic t_trusted_hold;
      pset(1'b1, 1'b0, '0, '0);
      wr(3, 32'hDEAD_BEEF, 32'h0, 1'b1);
      read_reg(3, "R3 hold", 32'hA5A5_3C3C, 32'h0000_F0F0);
   endtask

   task automatic t_untrusted_load;
      pset(1'b1, 1'b1, 32'h0000_0001, '0);
      chk("R7 val", 32'(pred_val[1]), 32'h1);
      chk("R7 taint a", 32'(pred_taint[1]), 32'h1);
      wr(4, 32'h1234_5678, 32'h0, 1'b1);
      read_reg(4, "R4 untrusted on", 32'h1234_5678, 32'hFFFF_FFFF);
   endtask

   task automatic t_untrusted_keep;
      pset(1'b1, 1'b0, '0, 32'h8000_0000);
      chk("R7 taint b", 32'(pred_taint[1]), 32'h1);
      wr(3, 32'h0BAD_F00D, 32'h0, 1'b1);
      read_reg(3, "R5 untrusted off", 32'hA5A5_3C3C, 32'hFFFF_FFFF);
      read_reg(4, "R6 r4 intact", 32'h1234_5678, 32'hFFFF_FFFF);
      for (int i = 0; i < 8; i++)
         if (i != 3 && i != 4) read_reg(i, "R6 others", 32'h0, 32'h0);
      pset(1'b1, 1'b0, '0, '0);
      chk("R7 clean taint", 32'(pred_taint[1]), 32'h0);
   endtask

   task automatic t_no_bypass;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd2; wr_data = 32'hCAFE_0002; wr_taint = 32'h3; wr_psel = 1'b0;
      rd0_idx = 3'd2;
      #1;
      chk("R8 same cycle data", rd0_data, 32'h0);
      chk("R8 same cycle taint", rd0_taint, 32'h0);
      @(posedge clk);
      #1;
      chk("R8 next cycle data", rd0_data, 32'hCAFE_0002);
      chk("R8 next cycle taint", rd0_taint, 32'h3);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_idle;
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 3'd2; wr_data = 32'hFFFF_0000; wr_taint = 32'hFFFF_FFFF; wr_psel = 1'b0;
      @(negedge clk);
      read_reg(2, "R9 idle", 32'hCAFE_0002, 32'h3);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      cmp_en = 1'b1; cmp_idx = 1'b0; cmp_result = 1'b0; cmp_a = 32'h10; cmp_b = '0;
      wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'h6666_6666; wr_taint = 32'h0; wr_psel = 1'b0;
      @(negedge clk);
      cmp_en = 1'b0; wr_en = 1'b0;
      read_reg(6, "R11 old pred used", 32'h6666_6666, 32'h0);
      @(negedge clk);
      cmp_en = 1'b1; cmp_idx = 1'b0; cmp_result = 1'b1; cmp_a = '0; cmp_b = '0;
      wr_en = 1'b1; wr_idx = 3'd7; wr_data = 32'h7777_7777; wr_taint = 32'h0; wr_psel = 1'b0;
      @(negedge clk);
      cmp_en = 1'b0; wr_en = 1'b0;
      read_reg(7, "R11 old tainted zero", 32'h0, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_trusted_load();
      t_trusted_hold();
      t_untrusted_load();
      t_untrusted_keep();
      t_no_bypass();
      t_idle();
      t_same_cycle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule